// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block times a successive-approximation converter from a conversion clock that it derives by dividing the system clock. Software starts a conversion through a start bit. The block then produces a sample-and-hold strobe and a result-latch strobe at fixed points in the conversion. At completion it captures a 10-bit result from an abstract data input, sets a sticky completion flag and, depending on the mode, clears the start bit or starts the next conversion.

Three modes are supported: single, free-running and auto-trigger. In auto-trigger mode, a rising edge on an external trigger resets the divider, so the time from trigger to sample never varies. The first conversion after the block is enabled runs a longer sequence, which gives the analog front end time to settle. The channel and reference selections are latched at the start of every conversion.

All logic runs on the system clock. The conversion clock exists as a pair of one-cycle rise and fall ticks plus a registered square-wave output.

Top module: `adc_seq_top`

## Requirements
- R1: With `psel` = p (0..6), the divider period is D = 2^(p+1) system cycles. While `enable` is low the divider counter and `conv_clk` are held at 0. `conv_clk` first goes high D-1 edges after the first edge that samples `enable` high, and then rises every D edges. Its falling tick comes D/2 edges after each rise.
- R2: A one-cycle `start_set` pulse makes `start_bit` read 1 from the next edge on. A conversion then begins at the first conversion-clock rise whose edge sees `start_bit` already 1.
- R3: The first conversion after `enable` rises lasts 25 conversion cycles: `latch_strobe` pulses 25·D edges after the start edge.
- R4: Every later conversion lasts 13 conversion cycles (latch 13·D edges after the start edge), and the latch only ever follows a conversion in progress.
- R5: `sh_strobe` pulses once per conversion, on a falling tick: 3.5·D edges after the start of a normal conversion and 13.5·D after the start of a first one. It never coincides with `latch_strobe`.
- R6: At completion, `result` takes the value of `sar_data` and `done_flag` is set. In single mode (`mode` 0, or 3) `start_bit` is cleared on the same edge. `result` does not change between completions.
- R7: In free-running mode (`mode` 1), the next conversion starts on the completion edge itself, and `start_bit` stays 1.
- R8: In auto-trigger mode (`mode` 2), a rising edge of `trig_in` that is first sampled at edge k starts a conversion at edge k+3 and resets the divider there. For a non-first conversion, `sh_strobe` then pulses at edge k+3+2·D and `latch_strobe` at edge k+3+13·D.
- R9: A trigger edge that arrives while a conversion is running starts nothing: no extra latch follows, and the block returns to idle.
- R10: `done_flag` stays set until a one-cycle `flag_clr` pulse clears it. If a completion and a clear fall on the same edge, the set wins.
- R11: While `enable` is low, any conversion is aborted without a latch, and `busy` and `start_bit` are 0. A `start_set` pulse in that time has no effect. The next conversion after re-enable is a 25-cycle first conversion.
- R12: `chan_lat` and `ref_lat` take `chan_sel` and `ref_sel` when a conversion starts and hold them through that conversion, even if the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter enable; low aborts and re-arms the first-conversion sequence |
| start_set | input | 1 | One-cycle software write of 1 to the start bit |
| mode | input | 2 | 0 single, 1 free-running, 2 auto-trigger, 3 treated as single |
| psel | input | 3 | Divider select, period 2^(psel+1) system cycles (0..6) |
| trig_in | input | 1 | Asynchronous external trigger |
| flag_clr | input | 1 | One-cycle write-1-to-clear of the completion flag |
| chan_sel | input | 5 | Requested channel |
| ref_sel | input | 2 | Requested reference |
| sar_data | input | 10 | Abstract conversion result presented by the converter |
| conv_clk | output | 1 | Divided conversion clock |
| busy | output | 1 | A conversion is in progress |
| start_bit | output | 1 | Start bit as read by software |
| sh_strobe | output | 1 | One-cycle sample-and-hold strobe |
| latch_strobe | output | 1 | One-cycle result-latch strobe |
| done_flag | output | 1 | Sticky completion flag |
| result | output | 10 | Last completed result |
| chan_lat | output | 5 | Channel latched at conversion start |
| ref_lat | output | 2 | Reference latched at conversion start |

## Verification
The bench sweeps every divider setting and, at each one, checks the sample and latch edges of both a first and a normal conversion against positions computed from the enable edge. This catches a sample placed on a rising tick instead of the half cycle, and a 25/13 length that is not re-armed. Free-running is checked for a latch exactly 13·D after the previous one with the start bit still high. A design that cleared the start bit or inserted an idle cycle would move that latch.

In auto-trigger mode, a second trigger edge is forced during the conversion. A sequencer that did not ignore it would latch twice. One that forgot to reset the divider would land the sample off the k+3+2·D edge. An enable pulse taken low mid-conversion must yield no latch and a following 25-cycle conversion.

// File: rtl/adc_seq_pkg.sv
// Package: shared mode encoding and default sequence lengths for the sequencer.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_FREE   = 2'd1,
        MODE_AUTO   = 2'd2,
        MODE_RSVD   = 2'd3
    } conv_mode_e;

    localparam int FIRST_LEN_DEF = 25;
    localparam int NORM_LEN_DEF  = 13;
    localparam int FIRST_SH_DEF  = 14;
    localparam int NORM_SH_DEF   = 4;
    localparam int AUTO_SH_DEF   = 2;

endpackage

// File: rtl/adc_prescaler.sv
// Module: adc_prescaler
// Divides the system clock by 2^(psel+1) and produces one-cycle rise and fall
// ticks of the conversion clock, plus a registered square-wave copy.
// Assumes psel <= CNT_W-1. The counter is cleared while disabled or on restart.
module adc_prescaler #(
    parameter int SEL_W = 3,
    localparam int CNT_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [SEL_W-1:0] psel,
    output logic             rise,
    output logic             fall,
    output logic             conv_clk
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] half;

    // Build the modulo mask: one bit per divider stage at or below psel.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask[i] = (psel >= SEL_W'(i));
    end

    assign half = mask >> 1;
    assign rise = enable && ((cnt & mask) == mask);
    assign fall = enable && ((cnt & mask) == half);

    // Free-running divider count, cleared when disabled or resynchronised.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Square-wave conversion clock, aligned with the ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || restart) begin
            conv_clk <= 1'b0;
        end else if (rise) begin
            conv_clk <= 1'b1;
        end else if (fall) begin
            conv_clk <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_trig_sync.sv
// Module: adc_trig_sync
// Brings the asynchronous trigger into the clock domain through two flops and
// registers a rising-edge pulse. Total latency from the first sampling edge to
// the usable pulse is three edges. Assumes trigger pulses last at least 2 cycles.
module adc_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_edge
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-flop synchroniser followed by the previous-value flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= trig_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Registered rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_edge <= 1'b0;
        end else begin
            trig_edge <= sync_q && !prev_q;
        end
    end

endmodule

// File: rtl/adc_conv_fsm.sv
// Module: adc_conv_fsm
// Counts conversion-clock cycles within a conversion and places the sample and
// latch strobes. Tracks whether the next conversion is the first since enable.
// Assumes rise/fall are one-cycle ticks and never fire while enable is low.
module adc_conv_fsm #(
    parameter int FIRST_LEN = adc_seq_pkg::FIRST_LEN_DEF,
    parameter int NORM_LEN  = adc_seq_pkg::NORM_LEN_DEF,
    parameter int FIRST_SH  = adc_seq_pkg::FIRST_SH_DEF,
    parameter int NORM_SH   = adc_seq_pkg::NORM_SH_DEF,
    parameter int AUTO_SH   = adc_seq_pkg::AUTO_SH_DEF,
    localparam int CYC_W    = $clog2(FIRST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic free_mode,
    input  logic trig_go,
    input  logic start_bit,
    input  logic rise,
    input  logic fall,
    output logic busy,
    output logic conv_start,
    output logic conv_done,
    output logic sh_strobe,
    output logic latch_strobe
);

    logic [CYC_W-1:0] cyc;
    logic             first;
    logic             auto_run;
    logic [CYC_W-1:0] len;
    logic             sample_hit;

    assign len        = first ? CYC_W'(FIRST_LEN) : CYC_W'(NORM_LEN);
    assign conv_start = enable && !busy && (trig_go || (start_bit && rise));
    assign conv_done  = enable && busy && rise && (cyc == len);

    // Select the sample point: a rising tick for a triggered run, else a falling one.
    always_comb begin
        if (auto_run && !first) begin
            sample_hit = rise && (cyc == CYC_W'(AUTO_SH));
        end else if (first) begin
            sample_hit = fall && (cyc == CYC_W'(FIRST_SH));
        end else begin
            sample_hit = fall && (cyc == CYC_W'(NORM_SH));
        end
    end

    // Conversion state: busy, cycle count, first-conversion and trigger-run flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy     <= 1'b0;
            cyc      <= '0;
            first    <= 1'b1;
            auto_run <= 1'b0;
        end else if (conv_start) begin
            busy     <= 1'b1;
            cyc      <= CYC_W'(1);
            auto_run <= trig_go;
        end else if (conv_done) begin
            first    <= 1'b0;
            auto_run <= 1'b0;
            cyc      <= free_mode ? CYC_W'(1) : '0;
            busy     <= free_mode;
        end else if (busy && rise) begin
            cyc <= cyc + 1'b1;
        end
    end

    // One-cycle strobe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sh_strobe    <= 1'b0;
            latch_strobe <= 1'b0;
        end else begin
            sh_strobe    <= busy && sample_hit;
            latch_strobe <= conv_done;
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
// Module: adc_seq_top
// Conversion timing sequencer: a divider, a trigger synchroniser and a cycle
// sequencer, plus the start bit, the completion flag, the result register and
// the input-selection latches. Single clock domain, synchronous active-low reset.
module adc_seq_top #(
    parameter int SEL_W = 3,
    parameter int RES_W = 10,
    parameter int CH_W  = 5,
    parameter int REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_set,
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] psel,
    input  logic             trig_in,
    input  logic             flag_clr,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic [REF_W-1:0] ref_sel,
    input  logic [RES_W-1:0] sar_data,
    output logic             conv_clk,
    output logic             busy,
    output logic             start_bit,
    output logic             sh_strobe,
    output logic             latch_strobe,
    output logic             done_flag,
    output logic [RES_W-1:0] result,
    output logic [CH_W-1:0]  chan_lat,
    output logic [REF_W-1:0] ref_lat
);
    import adc_seq_pkg::*;

    conv_mode_e mode_e;
    logic       rise;
    logic       fall;
    logic       trig_edge;
    logic       trig_go;
    logic       free_mode;
    logic       conv_start;
    logic       conv_done;

    assign mode_e    = conv_mode_e'(mode);
    assign free_mode = (mode_e == MODE_FREE);
    assign trig_go   = trig_edge && enable && !busy && (mode_e == MODE_AUTO);

    adc_prescaler #(.SEL_W(SEL_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .restart  (trig_go),
        .psel     (psel),
        .rise     (rise),
        .fall     (fall),
        .conv_clk (conv_clk)
    );

    adc_trig_sync u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (trig_in),
        .trig_edge (trig_edge)
    );

    adc_conv_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .free_mode    (free_mode),
        .trig_go      (trig_go),
        .start_bit    (start_bit),
        .rise         (rise),
        .fall         (fall),
        .busy         (busy),
        .conv_start   (conv_start),
        .conv_done    (conv_done),
        .sh_strobe    (sh_strobe),
        .latch_strobe (latch_strobe)
    );

    // Start bit: set by software or trigger, cleared by a non-free completion or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            start_bit <= 1'b0;
        end else if (conv_done && !free_mode) begin
            start_bit <= 1'b0;
        end else if (start_set || trig_go) begin
            start_bit <= 1'b1;
        end
    end

    // Sticky completion flag; a completion outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (conv_done) begin
            done_flag <= 1'b1;
        end else if (flag_clr) begin
            done_flag <= 1'b0;
        end
    end

    // Result capture at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (conv_done) begin
            result <= sar_data;
        end
    end

    // Channel and reference latched whenever a conversion begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_lat <= '0;
            ref_lat  <= '0;
        end else if (conv_start || (conv_done && free_mode)) begin
            chan_lat <= chan_sel;
            ref_lat  <= ref_sel;
        end
    end

endmodule

// File: rtl/adc_seq_chk.sv
// Module: adc_seq_chk
// Temporal checks on the sequencer's ports, bound to every adc_seq_top instance.
module adc_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [1:0]       mode,
    input logic             flag_clr,
    input logic             busy,
    input logic             start_bit,
    input logic             sh_strobe,
    input logic             latch_strobe,
    input logic             done_flag,
    input logic [RES_W-1:0] result
);

    // R6: a latch always leaves the flag set
    a_r6_latch_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |-> done_flag);

    // R6: single mode clears the start bit with the latch
    a_r6_single_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_strobe && $past(mode) != 2'd1 && $past(mode) != 2'd2) |-> !start_bit);

    // R7: free-running keeps the start bit high across a latch
    a_r7_free_keeps_start: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_strobe && $past(mode) == 2'd1) |-> start_bit);

    // R6: the result only moves on a latch
    a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_strobe |-> $stable(result));

    // R5: sample and latch never coincide
    a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_strobe && latch_strobe));

    // R4: a latch only follows a conversion in progress
    a_r4_latch_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        latch_strobe |-> $past(busy));

    // R10: the flag holds until cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done_flag) && !$past(flag_clr)) |-> done_flag);

    // R11: disabling idles the sequencer and clears the start bit
    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !start_bit));

endmodule

bind adc_seq_top adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .mode         (mode),
    .flag_clr     (flag_clr),
    .busy         (busy),
    .start_bit    (start_bit),
    .sh_strobe    (sh_strobe),
    .latch_strobe (latch_strobe),
    .done_flag    (done_flag),
    .result       (result)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
// Bench: sweeps every divider setting and each mode, with expected strobe
// edges computed arithmetically from the edge at which stimulus was sampled.
module sim_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start_set = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] psel = 3'd0;
    logic       trig_in = 1'b0;
    logic       flag_clr = 1'b0;
    logic [4:0] chan_sel = '0;
    logic [1:0] ref_sel = '0;
    logic [9:0] sar_data = '0;
    logic       conv_clk, busy, start_bit, sh_strobe, latch_strobe, done_flag;
    logic [9:0] result;
    logic [4:0] chan_lat;
    logic [1:0] ref_lat;

    int tcyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    int sh_at = 0, sh_cnt = 0, lat_at = 0, lat_cnt = 0;
    int rise_cnt = 0, rise_at = 0, rise_prev = 0;
    logic cc_prev = 1'b0;
    int D = 2;
    int e = 0;

    always #2 clk = ~clk;

    adc_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_set(start_set),
        .mode(mode), .psel(psel), .trig_in(trig_in), .flag_clr(flag_clr),
        .chan_sel(chan_sel), .ref_sel(ref_sel), .sar_data(sar_data),
        .conv_clk(conv_clk), .busy(busy), .start_bit(start_bit),
        .sh_strobe(sh_strobe), .latch_strobe(latch_strobe),
        .done_flag(done_flag), .result(result), .chan_lat(chan_lat),
        .ref_lat(ref_lat)
    );

    always @(posedge clk) tcyc <= tcyc + 1;

    // Event monitor, 1 ns after each edge; tcyc then equals that edge's index.
    always @(posedge clk) begin
        #1;
        if (sh_strobe) begin sh_at = tcyc; sh_cnt++; end
        if (latch_strobe) begin lat_at = tcyc; lat_cnt++; end
        if (conv_clk && !cc_prev) begin rise_prev = rise_at; rise_at = tcyc; rise_cnt++; end
        cc_prev = conv_clk;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_set = 1'b1; tick(1); start_set = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
    endtask

    function automatic int next_rise(int from);
        int n = from + 1;
        while (((n - e) % D) != D - 1) n++;
        return n;
    endfunction

    task automatic wait_lat(int target, int limit, string tag);
        for (int i = 0; i < limit && lat_cnt < target; i++) tick(1);
        if (lat_cnt < target) chk(tag, lat_cnt, target);
    endtask

    task automatic wait_busy(string tag);
        for (int i = 0; i < 4 * D + 8 && !busy; i++) tick(1);
        if (!busy) chk(tag, 0, 1);
    endtask

    // Software-started conversion in single mode with timing, result and latch checks.
    task automatic do_single(bit first, logic [9:0] val, logic [4:0] ch);
        int s, r, sh0, l0;
        chan_sel = ch; ref_sel = ch[1:0]; sar_data = val;
        sh0 = sh_cnt; l0 = lat_cnt;
        s = tcyc + 1;
        pulse_start();
        chk("R2 start_bit set", int'(start_bit), 1);
        r = next_rise(s);
        wait_busy("R2 conversion begins");
        chan_sel = ~ch; ref_sel = ~ch[1:0];
        wait_lat(l0 + 1, 30 * D + 20, "R3 latch occurs");
        tick(1);
        if (first) begin
            chk("R5 first sample edge", sh_at, r + 13 * D + D / 2);
            chk("R3 first latch edge", lat_at, r + 25 * D);
        end else begin
            chk("R5 normal sample edge", sh_at, r + 3 * D + D / 2);
            chk("R4 normal latch edge", lat_at, r + 13 * D);
        end
        chk("R5 one sample per conversion", sh_cnt, sh0 + 1);
        chk("R6 result captured", int'(result), int'(val));
        chk("R6 flag set", int'(done_flag), 1);
        chk("R6 single clears start", int'(start_bit), 0);
        chk("R12 channel held", int'(chan_lat), int'(ch));
        chk("R12 reference held", int'(ref_lat), int'(ch[1:0]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", tcyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset conv_clk", int'(conv_clk), 0);
        chk("R6 reset flag", int'(done_flag), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R6 reset result", int'(result), 0);

        // Divider sweep: first and normal conversion at every setting.
        for (int p = 0; p < 7; p++) begin
            int rc;
            enable = 1'b0; psel = 3'(p); mode = 2'd0; D = 2 << p;
            tick(2);
            pulse_clr();
            rc = rise_cnt;
            e = tcyc + 1;
            enable = 1'b1;
            for (int i = 0; i < 3 * D + 8 && rise_cnt < rc + 2; i++) tick(1);
            chk("R1 first rise", rise_prev, e + D - 1);
            chk("R1 period", rise_at - rise_prev, D);
            do_single(1'b1, 10'(10'h2A5 ^ (p * 37)), 5'(p + 3));
            pulse_clr();
            chk("R10 flag cleared", int'(done_flag), 0);
            do_single(1'b0, 10'(10'h0F3 + p * 91), 5'(p + 17));
        end

        // Free-running at D = 8.
        enable = 1'b0; psel = 3'd2; D = 8; tick(2);
        e = tcyc + 1; enable = 1'b1;
        do_single(1'b1, 10'h155, 5'd9);
        tick(5);
        chk("R10 flag holds", int'(done_flag), 1);
        pulse_clr();
        chk("R10 flag cleared by write", int'(done_flag), 0);
        mode = 2'd1;
        begin
            int s, r, l0;
            l0 = lat_cnt;
            s = tcyc + 1;
            pulse_start();
            r = next_rise(s);
            wait_lat(l0 + 1, 20 * D, "R7 first free latch");
            tick(1);
            chk("R7 first free latch edge", lat_at, r + 13 * D);
            chk("R7 start stays high", int'(start_bit), 1);
            chk("R7 still busy", int'(busy), 1);
            mode = 2'd0;
            wait_lat(l0 + 2, 20 * D, "R7 second free latch");
            tick(1);
            chk("R7 back-to-back latch edge", lat_at, r + 26 * D);
            chk("R6 single stops run", int'(start_bit), 0);
        end

        // Auto-trigger with a second edge during the conversion.
        mode = 2'd2; trig_in = 1'b0; tick(4);
        begin
            int k, l0;
            l0 = lat_cnt;
            k = tcyc + 1;
            trig_in = 1'b1;
            tick(10); trig_in = 1'b0;
            tick(10); trig_in = 1'b1;
            wait_lat(l0 + 1, 20 * D, "R8 trigger latch");
            tick(1);
            chk("R8 trigger sample edge", sh_at, k + 3 + 2 * D);
            chk("R8 trigger latch edge", lat_at, k + 3 + 13 * D);
            trig_in = 1'b0;
            tick(30 * D);
            chk("R9 no extra latch", lat_cnt, l0 + 1);
            chk("R9 idle after ignored edge", int'(busy), 0);
        end

        // Abort by disable, then a re-armed first conversion.
        mode = 2'd0; pulse_clr();
        begin
            int l0;
            l0 = lat_cnt;
            pulse_start();
            wait_busy("R11 conversion begins");
            tick(5);
            enable = 1'b0;
            tick(1);
            chk("R11 abort clears busy", int'(busy), 0);
            chk("R11 abort clears start", int'(start_bit), 0);
            pulse_start();
            chk("R11 start ignored while disabled", int'(start_bit), 0);
            tick(3);
            chk("R11 no latch after abort", lat_cnt, l0);
            chk("R11 flag untouched", int'(done_flag), 0);
            e = tcyc + 1; enable = 1'b1;
            do_single(1'b1, 10'h3C1, 5'd21);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule